// File: doc/BRIEF.md
# Probabilistic Bit-Flipping LDPC Decoder Core

This block decodes a hard-decision word received over a binary symmetric channel using a small regular low-density parity-check code. The code is quasi-cyclic, with column weight 3 and row weight 5, and its connectivity is fixed at compile time. A start pulse loads the received word. The decoder then performs one complete decoding iteration in every clock cycle.

In each iteration the decoder works out the parity of every check node. For each variable node it forms an inversion metric: the disagreement between the current bit and the received bit, plus the count of unsatisfied checks that touch the node. A tree of comparators finds the largest metric. Only the nodes whose metric equals that maximum may invert their bit, and a node inverts only when its random enable bit is set in that same cycle. The random enable bits come from outside the block, so the caller chooses how random they are.

Decoding stops as soon as every check is satisfied, or when the iteration limit is reached. At that point the decoder raises a one-cycle done pulse, sets a success flag and presents the decoded word.

Top module: `bfDecoder`

## Requirements
- R1: With circulant size P, variable column c = b*P + t (b = 0..4, t = 0..P-1) connects to the three check rows r*P + ((t + r*b) mod P) for r = 0, 1, 2. Check row m is unsatisfied when the XOR of the current bits of all its columns is 1.
- R2: A start pulse while idle copies rxWord into decWord at that clock edge, and busy is 1 in the following cycle.
- R3: When all checks are satisfied at the start of a busy cycle, decoding ends with success = 1 and no bit changes. A received word that is already a codeword therefore finishes with zero iterations, and done is seen one cycle after the load edge.
- R4: The metric of a node is (decWord bit XOR received bit) plus its number of unsatisfied checks, so it ranges from 0 to 4. The threshold is the largest metric over all nodes. A bit inverts exactly when its metric equals the threshold and its randEn bit is 1 in that cycle.
- R5: A node whose randEn bit is 0 keeps its bit in that iteration, whatever its metric.
- R6: Each iteration takes one clock cycle. A decode that performs k iterations shows done k+1 cycles after the load edge.
- R7: After IMAX iterations that leave some check unsatisfied, decoding ends with success = 0, and decWord holds the word reached.
- R8: done is a single-cycle pulse with busy low. success stays valid after done until the next start.
- R9: A start pulse while busy is ignored. The running decode and its result are unaffected.
- R10: After reset, busy, done and success are 0 and decWord is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load rxWord and begin decoding (ignored while busy) |
| rxWord | input | N | Received hard-decision word |
| randEn | input | N | Per-node random flip enable, sampled in each iteration cycle |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | One-cycle pulse when decoding ends |
| success | output | 1 | All checks satisfied at the end of decoding |
| decWord | output | N | Current or final decoded word |

## Verification
The decoder is driven with a clean codeword, which must finish at once. It is then driven with a single error and all enables set, which must be corrected in exactly one iteration. Two separated errors with only one enable set show that flipping is gated per node: one bit is fixed and the other stays stuck until the limit. An all-zero enable shows that nothing moves and the limit ends the run. Several multi-error words under mixed enable masks are compared against a bench model of the metric, threshold and flip rule, which checks both the final word and the iteration count. A start pulsed in mid-run with a different word shows that a busy decoder ignores it.

// File: rtl/bfDecPkg.sv
package bfDecPkg;

  typedef struct packed {
    logic load;
    logic flip;
  } bfStrobe_t;

  // Check row reached by column col through row block rb (circulant code).
  function automatic int rowOf(input int col, input int rb, input int p);
    int b;
    int t;
    b = col / p;
    t = col % p;
    return rb * p + ((t + rb * b) % p);
  endfunction

endpackage

// File: rtl/bfMaxTree.sv
module bfMaxTree #(
  parameter int NL = 25,
  parameter int W  = 3
) (
  input  logic [NL*W-1:0] leafs,
  output logic [W-1:0]    maxVal
);
  localparam int LV = $clog2(NL);
  localparam int L  = 1 << LV;

  logic [W-1:0] node [2*L-1];

  genvar j, i;
  generate
    for (j = 0; j < L; j++) begin : g_leaf
      if (j < NL) begin : g_used
        assign node[L-1+j] = leafs[j*W +: W];
      end else begin : g_pad
        assign node[L-1+j] = '0;
      end
    end
    for (i = 0; i < L-1; i++) begin : g_cmp
      assign node[i] = (node[2*i+1] >= node[2*i+2]) ? node[2*i+1] : node[2*i+2];
    end
  endgenerate

  assign maxVal = node[0];
endmodule

// File: rtl/bfDatapath.sv
module bfDatapath import bfDecPkg::*; #(
  parameter int P  = 5,
  parameter int DV = 3,
  parameter int DC = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  bfStrobe_t           strobe,
  input  logic [P*DC-1:0]     rxWord,
  input  logic [P*DC-1:0]     randEn,
  output logic                synZero,
  output logic [P*DC-1:0]     decWord
);
  localparam int N  = P * DC;
  localparam int M  = P * DV;
  localparam int MW = $clog2(DV + 2);

  logic [N-1:0]    varReg;
  logic [N-1:0]    rxReg;
  logic [M-1:0]    syn;
  logic [N*MW-1:0] metricFlat;
  logic [MW-1:0]   thr;
  logic [N-1:0]    isMax;

  always_comb begin
    syn = '0;
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < DV; r++) begin
        syn[rowOf(c, r, P)] = syn[rowOf(c, r, P)] ^ varReg[c];
      end
    end
  end

  assign synZero = (syn == '0);

  always_comb begin
    metricFlat = '0;
    for (int c = 0; c < N; c++) begin
      metricFlat[c*MW +: MW] = MW'(varReg[c] ^ rxReg[c]);
      for (int r = 0; r < DV; r++) begin
        metricFlat[c*MW +: MW] = metricFlat[c*MW +: MW] + MW'(syn[rowOf(c, r, P)]);
      end
    end
  end

  bfMaxTree #(.NL(N), .W(MW)) maxTree (
    .leafs  (metricFlat),
    .maxVal (thr)
  );

  always_comb begin
    for (int c = 0; c < N; c++) begin
      isMax[c] = (metricFlat[c*MW +: MW] == thr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      varReg <= '0;
      rxReg  <= '0;
    end else if (strobe.load) begin
      varReg <= rxWord;
      rxReg  <= rxWord;
    end else if (strobe.flip) begin
      varReg <= varReg ^ (isMax & randEn);
    end
  end

  assign decWord = varReg;
endmodule

// File: rtl/bfControl.sv
module bfControl import bfDecPkg::*; #(
  parameter int IMAX = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      synZero,
  output bfStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      success
);
  localparam int IW = $clog2(IMAX + 1);

  typedef enum logic {ST_IDLE, ST_RUN} bfState_t;

  bfState_t      state;
  logic [IW-1:0] iterCnt;
  logic          limitHit;

  assign limitHit    = (iterCnt == IW'(IMAX));
  assign strobe.load = (state == ST_IDLE) && start;
  assign strobe.flip = (state == ST_RUN) && !synZero && !limitHit;
  assign busy        = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
      success <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
            success <= 1'b0;
          end
        end
        ST_RUN: begin
          if (synZero) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            success <= 1'b1;
          end else if (limitHit) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            success <= 1'b0;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bfDecoder.sv
module bfDecoder import bfDecPkg::*; #(
  parameter int P    = 5,
  parameter int DV   = 3,
  parameter int DC   = 5,
  parameter int IMAX = 20,
  localparam int N   = P * DC
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [N-1:0] rxWord,
  input  logic [N-1:0] randEn,
  output logic         busy,
  output logic         done,
  output logic         success,
  output logic [N-1:0] decWord
);
  bfStrobe_t strobe;
  logic      synZero;

  bfControl #(.IMAX(IMAX)) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .synZero (synZero),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done),
    .success (success)
  );

  bfDatapath #(.P(P), .DV(DV), .DC(DC)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxWord  (rxWord),
    .randEn  (randEn),
    .synZero (synZero),
    .decWord (decWord)
  );
endmodule

// File: rtl/bfDecoderChk.sv
module bfDecoderChk #(
  parameter int N    = 25,
  parameter int IMAX = 20
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [N-1:0] rxWord,
  input logic [N-1:0] randEn,
  input logic         busy,
  input logic         done,
  input logic         success,
  input logic [N-1:0] decWord
);
  localparam int CW = $clog2(IMAX + 2) + 1;

  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else       busyCnt <= busy ? busyCnt + 1'b1 : '0;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && decWord == $past(rxWord)));

  p_hold_noen_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (((decWord ^ $past(decWord)) & ~$past(randEn)) == '0));

  p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt <= CW'(IMAX)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_success_at_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(success) |-> done);

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && randEn == '0) |=> (decWord == $past(decWord)));
endmodule

bind bfDecoder bfDecoderChk #(.N(N), .IMAX(IMAX)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .rxWord  (rxWord),
  .randEn  (randEn),
  .busy    (busy),
  .done    (done),
  .success (success),
  .decWord (decWord)
);

// File: tb/tb_bfDecoder.sv
`timescale 1ns/1ps
module tb_bfDecoder;
  localparam int P    = 5;
  localparam int DV   = 3;
  localparam int DC   = 5;
  localparam int IMAX = 20;
  localparam int N    = P * DC;
  localparam int M    = P * DV;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] rxWord = '0;
  logic [N-1:0] randEn = '0;
  logic         busy, done, success;
  logic [N-1:0] decWord;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bfDecoder #(.P(P), .DV(DV), .DC(DC), .IMAX(IMAX)) dut (
    .clk(clk), .rstN(rstN), .start(start), .rxWord(rxWord), .randEn(randEn),
    .busy(busy), .done(done), .success(success), .decWord(decWord)
  );

  // R1 connectivity, computed from the requirement
  function automatic int rowRef(input int c, input int r);
    return r * P + (((c % P) + r * (c / P)) % P);
  endfunction

  function automatic logic [M-1:0] synRef(input logic [N-1:0] v);
    logic [M-1:0] s = '0;
    for (int c = 0; c < N; c++)
      for (int r = 0; r < DV; r++) s[rowRef(c, r)] ^= v[c];
    return s;
  endfunction

  // R4 flip rule
  function automatic logic [N-1:0] stepRef(input logic [N-1:0] v, rx, ren);
    logic [M-1:0] s;
    int met [N];
    int mx = 0;
    logic [N-1:0] nv;
    s = synRef(v);
    for (int c = 0; c < N; c++) begin
      met[c] = int'(v[c] ^ rx[c]);
      for (int r = 0; r < DV; r++) met[c] += int'(s[rowRef(c, r)]);
      if (met[c] > mx) mx = met[c];
    end
    nv = v;
    for (int c = 0; c < N; c++) if (met[c] == mx && ren[c]) nv[c] = ~v[c];
    return nv;
  endfunction

  task automatic predict(input logic [N-1:0] rx, ren,
                         output logic [N-1:0] w, output logic s, output int cyc);
    int k = 0;
    w = rx;
    forever begin
      if (synRef(w) == '0) begin s = 1'b1; break; end
      if (k == IMAX) begin s = 1'b0; break; end
      w = stepRef(w, rx, ren);
      k++;
    end
    cyc = k + 1;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one decode; poke pulses start with a different word mid-run.
  task automatic runCase(input logic [N-1:0] rx, ren, input bit poke,
                         output logic [N-1:0] wOut, output logic sOut, output int cyc);
    @(negedge clk);
    rxWord = rx; randEn = ren; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && decWord === rx, "R2 load", {38'd0, busy, decWord}, {38'd0, 1'b1, rx});
    cyc = 0;
    while (done !== 1'b1 && cyc < IMAX + 10) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin start = 1'b1; rxWord = ~rx; end
      else if (poke && cyc == 4) start = 1'b0;
    end
    wOut = decWord;
    sOut = success;
    check(busy === 1'b0, "R8 busy low at done", 64'(busy), 64'd0);
    @(negedge clk);
    check(done === 1'b0 && success === sOut, "R8 done pulse / success held",
          {62'd0, done, success}, {62'd0, 1'b0, sOut});
    start = 1'b0;
  endtask

  task automatic tReset;
    check(busy === 0 && done === 0 && success === 0 && decWord === '0, "R10 reset",
          {36'd0, busy, done, success, decWord}, 64'd0);
  endtask

  task automatic tCleanWord;
    logic [N-1:0] w; logic s; int cyc;
    runCase('0, '1, 1'b0, w, s, cyc);
    check(cyc == 1, "R3 zero iterations", 64'(cyc), 64'd1);
    check(s === 1'b1 && w === '0, "R3 clean word unchanged", {38'd0, s, w}, {38'd0, 1'b1, 25'd0});
  endtask

  task automatic tSingleError;
    logic [N-1:0] w; logic s; int cyc;
    runCase(N'(1) << 7, '1, 1'b0, w, s, cyc);
    check(cyc == 2, "R6 one iteration per cycle", 64'(cyc), 64'd2);
    check(s === 1'b1 && w === '0, "R4 single error fixed", {38'd0, s, w}, {38'd0, 1'b1, 25'd0});
  endtask

  task automatic tNoEnable;
    logic [N-1:0] w; logic s; int cyc;
    logic [N-1:0] rx = (N'(1) << 2) | (N'(1) << 19);
    runCase(rx, '0, 1'b0, w, s, cyc);
    check(w === rx, "R5 no enable keeps word", 64'(w), 64'(rx));
    check(s === 1'b0 && cyc == IMAX + 1, "R7 limit reached", {31'd0, s, 32'(cyc)}, {31'd0, 1'b0, 32'(IMAX + 1)});
  endtask

  task automatic tPartialEnable;
    logic [N-1:0] w; logic s; int cyc;
    logic [N-1:0] rx = N'(3);
    runCase(rx, N'(1), 1'b0, w, s, cyc);
    check(w === N'(2), "R4 gated flip of max nodes", 64'(w), 64'd2);
    check(s === 1'b0 && cyc == IMAX + 1, "R7 stuck at limit", {31'd0, s, 32'(cyc)}, {31'd0, 1'b0, 32'(IMAX + 1)});
  endtask

  task automatic tModel;
    logic [N-1:0] rxs [6];
    logic [N-1:0] rens [3];
    logic [N-1:0] w, ew; logic s, es; int cyc, ecyc;
    rxs[0] = (N'(1) << 0) | (N'(1) << 6);
    rxs[1] = (N'(1) << 3) | (N'(1) << 11) | (N'(1) << 24);
    rxs[2] = (N'(1) << 5) | (N'(1) << 10);
    rxs[3] = (N'(1) << 1) | (N'(1) << 8) | (N'(1) << 17) | (N'(1) << 22);
    rxs[4] = (N'(1) << 12) | (N'(1) << 13);
    rxs[5] = 25'h1ABCDEF;
    rens[0] = '1;
    rens[1] = 25'h0AAAAAA;
    rens[2] = 25'h1B6DB6D;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 3; j++) begin
        predict(rxs[i], rens[j], ew, es, ecyc);
        runCase(rxs[i], rens[j], 1'b0, w, s, cyc);
        check(w === ew, "R1 R4 model word", 64'(w), 64'(ew));
        check(s === es, "R3 R7 model success", 64'(s), 64'(es));
        check(cyc == ecyc, "R6 model iteration count", 64'(cyc), 64'(ecyc));
      end
    end
  endtask

  task automatic tBusyStart;
    logic [N-1:0] w; logic s; int cyc;
    logic [N-1:0] rx = N'(1) << 3;
    runCase(rx, '0, 1'b1, w, s, cyc);
    check(w === rx && s === 1'b0, "R9 start while busy ignored", {38'd0, s, w}, {38'd0, 1'b0, rx});
    check(cyc == IMAX + 1, "R9 run length unchanged", 64'(cyc), 64'(IMAX + 1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCleanWord();
    tSingleError();
    tNoEnable();
    tPartialEnable();
    tModel();
    tBusyStart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule